// File: doc/BRIEF.md
# Host-to-Console Byte Bridge

This block links a host register port to the console of an embedded CPU without any serial wire in between. Two 16-byte queues carry characters, one in each direction. The host places a character in a transmit register, and the CPU later takes it from its own receive register. The CPU places a character in its transmit register, and the host collects it from a single receive word. That word holds the character, a valid flag and the current fill level of the queue. Reading that word consumes the character.

Both sides can read a status word at offset 0x0. Bit 0 reports that the CPU-to-host queue is full, so the CPU side is busy. Bit 1 reports that characters from the host are still waiting for the CPU. A host driver sends a character only after bit 1 has cleared. It empties the inbound side by reading the receive word again and again until the valid flag reads 0. Each side reaches its registers through a plain read/write strobe port. Read data is combinational and depends on the address and strobe of the current cycle. Any pop or push takes effect at the next rising clock edge.

Top module: `vuart_bridge`

## Requirements
- R1: After a synchronous active-low reset, both queues are empty. On each side the status word reads 0, the host receive word (0x14) reads 0, and the CPU receive word (0x8) reads 0.
- R2: A CPU read of offset 0x8 while the host-to-CPU queue holds data returns the oldest byte in bits 7:0 and 1 in bit 8, and removes that byte. When that queue is empty, the read returns 0 and changes nothing.
- R3: A host write to offset 0x10 appends bits 7:0 of the write data to the host-to-CPU queue. A write made while that queue already holds 16 bytes is dropped, and the bytes already queued are unchanged.
- R4: Status bit 1 reads 1 on both sides exactly while the host-to-CPU queue is non-empty.
- R5: A host read of offset 0x14 while the CPU-to-host queue is non-empty returns the oldest byte in bits 7:0, 1 in bit 8, and the number of bytes held before the read, zero-extended to 16 bits, in bits 24:9. The read removes that byte.
- R6: A host read of offset 0x14 while the CPU-to-host queue is empty returns 0 and leaves the queue unchanged.
- R7: A CPU write to offset 0x4 appends a byte to the CPU-to-host queue. Status bit 0 reads 1 exactly while that queue holds 16 bytes, and a CPU write made in that state is dropped.
- R8: A read of the transmit offset (host 0x10, CPU 0x4) returns 1 in bit 8 exactly while the matching outbound queue has room. All other bits read 0.
- R9: Each queue delivers bytes in the order they were accepted. This holds even when a push and a pop fall in the same cycle.
- R10: With the read strobe low, or at any unmapped offset, read data is 0 and no byte is removed. Bits 31:25 of every read are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_re | input | 1 | Host read strobe |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| cpu_re | input | 1 | CPU read strobe |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 5 | CPU byte offset |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |

## Verification
A wrong pointer or fill level in either queue shows at the ports on the very next read of a receive word, which returns a stale byte, a wrong count field or a wrong valid flag. It also shows within one cycle in the status bits, which both sides see. A dropped or duplicated push appears as a gap or a repeat in the stream that the other side drains. A missed full check appears as a seventeenth byte that should not exist. The reference model follows every accepted push and pop, so each of these faults is flagged in the cycle where it first reaches read data.

// File: rtl/vub_pkg.sv
// Shared offsets and types for the host-to-console byte bridge.
package vub_pkg;
    typedef logic [7:0] byte_t;

    // Host-side offsets (the driver decodes these positions)
    localparam logic [7:0] OFF_STATUS  = 8'h00;
    localparam logic [7:0] OFF_HOST_TX = 8'h10;
    localparam logic [7:0] OFF_HOST_RX = 8'h14;
    // CPU-side offsets
    localparam logic [7:0] OFF_CPU_TX  = 8'h04;
    localparam logic [7:0] OFF_CPU_RX  = 8'h08;
endpackage

// File: rtl/vub_fifo.sv
// Byte queue with guarded push and pop.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// A push is accepted only when the queue is not full, and a pop only when
// it is not empty. Both tests use the state before the clock edge.
module vub_fifo
    import vub_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  byte_t         push_byte,
    input  logic          pop_req,
    output byte_t         head_byte,
    output logic [LW-1:0] level
);
    byte_t         store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign push_ok   = push_req && (level != LW'(DEPTH));
    assign pop_ok    = pop_req && (level != '0);
    assign head_byte = store[rd_ptr];

    // Write the accepted byte into the slot at the write pointer
    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= push_byte;
    end

    // Advance the pointers and the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    // R3: the level never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R3 / R7: a push into a full queue, with no pop, leaves it full
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && push_req && !pop_req) |=> level == LW'(DEPTH));
    // R6: a pop from an empty queue, with no push, leaves it empty
    a_r6_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && pop_req && !push_req) |=> level == '0);
    // R9: the pointer gap matches the fill level
    a_r9_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr - rd_ptr) == level[AW-1:0]);
endmodule

// File: rtl/vub_host_regs.sv
// Host register decode: status at 0x0, transmit at 0x10, receive at 0x14.
// Assumes reads are combinational. A receive read pops the inbound queue
// only when that queue holds data.
module vub_host_regs
    import vub_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LW     = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        status,
    input  byte_t             in_head,
    input  logic [LW-1:0]     in_level,
    input  logic              out_room,
    output logic [31:0]       rdata,
    output logic              out_push,
    output byte_t             out_byte,
    output logic              in_pop
);
    logic hit_stat, hit_tx, hit_rx;

    assign hit_stat = (addr == ADDR_W'(OFF_STATUS));
    assign hit_tx   = (addr == ADDR_W'(OFF_HOST_TX));
    assign hit_rx   = (addr == ADDR_W'(OFF_HOST_RX));

    assign out_push = we && hit_tx;
    assign out_byte = wdata[7:0];
    assign in_pop   = re && hit_rx;

    // Select the read word for the addressed register
    always_comb begin
        rdata = '0;
        if (re) begin
            if (hit_stat)
                rdata[1:0] = status;
            else if (hit_tx)
                rdata[8] = out_room;
            else if (hit_rx && in_level != '0)
                rdata[24:0] = {CNT_W'(in_level), 1'b1, in_head};
        end
    end

    // R5: a receive read with data present reports valid and a nonzero count
    a_r5_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop && in_level != '0) |-> (rdata[8] && rdata[24:9] != '0));
    // R10: the top bits are always zero
    a_r10_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[31:25] == '0);
endmodule

// File: rtl/vub_cpu_regs.sv
// CPU register decode: status at 0x0, transmit at 0x4, receive at 0x8.
// Assumes reads are combinational. A receive read pops the inbound queue
// only when that queue holds data.
module vub_cpu_regs
    import vub_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        status,
    input  byte_t             in_head,
    input  logic [LW-1:0]     in_level,
    input  logic              out_room,
    output logic [31:0]       rdata,
    output logic              out_push,
    output byte_t             out_byte,
    output logic              in_pop
);
    logic hit_stat, hit_tx, hit_rx;

    assign hit_stat = (addr == ADDR_W'(OFF_STATUS));
    assign hit_tx   = (addr == ADDR_W'(OFF_CPU_TX));
    assign hit_rx   = (addr == ADDR_W'(OFF_CPU_RX));

    assign out_push = we && hit_tx;
    assign out_byte = wdata[7:0];
    assign in_pop   = re && hit_rx;

    // Select the read word for the addressed register
    always_comb begin
        rdata = '0;
        if (re) begin
            if (hit_stat)
                rdata[1:0] = status;
            else if (hit_tx)
                rdata[8] = out_room;
            else if (hit_rx && in_level != '0)
                rdata[8:0] = {1'b1, in_head};
        end
    end

    // R2: an empty receive read returns zero
    a_r2_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop && in_level == '0) |-> rdata == '0);
endmodule

// File: rtl/vuart_bridge.sv
// Top level of the host-to-console byte bridge.
// Holds two byte queues, host-to-CPU and CPU-to-host, and the register
// decoders on each side. The status word is shared by both sides.
module vuart_bridge
    import vub_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_re,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              cpu_re,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata
);
    localparam int LW = $clog2(DEPTH) + 1;

    byte_t         h2c_head, c2h_head, h2c_in, c2h_in;
    logic [LW-1:0] h2c_level, c2h_level;
    logic          h2c_push, h2c_pop, c2h_push, c2h_pop;
    logic [1:0]    status;

    // Status: bit 1 = data waiting for the CPU, bit 0 = CPU outbound full
    assign status = {h2c_level != '0, c2h_level == LW'(DEPTH)};

    vub_fifo #(.DEPTH(DEPTH)) u_h2c (
        .clk(clk), .rst_n(rst_n), .push_req(h2c_push), .push_byte(h2c_in),
        .pop_req(h2c_pop), .head_byte(h2c_head), .level(h2c_level));

    vub_fifo #(.DEPTH(DEPTH)) u_c2h (
        .clk(clk), .rst_n(rst_n), .push_req(c2h_push), .push_byte(c2h_in),
        .pop_req(c2h_pop), .head_byte(c2h_head), .level(c2h_level));

    vub_host_regs #(.ADDR_W(ADDR_W), .LW(LW), .CNT_W(CNT_W)) u_host (
        .clk(clk), .rst_n(rst_n), .re(host_re), .we(host_we),
        .addr(host_addr), .wdata(host_wdata), .status(status),
        .in_head(c2h_head), .in_level(c2h_level),
        .out_room(h2c_level != LW'(DEPTH)), .rdata(host_rdata),
        .out_push(h2c_push), .out_byte(h2c_in), .in_pop(c2h_pop));

    vub_cpu_regs #(.ADDR_W(ADDR_W), .LW(LW)) u_cpu (
        .clk(clk), .rst_n(rst_n), .re(cpu_re), .we(cpu_we),
        .addr(cpu_addr), .wdata(cpu_wdata), .status(status),
        .in_head(h2c_head), .in_level(h2c_level),
        .out_room(c2h_level != LW'(DEPTH)), .rdata(cpu_rdata),
        .out_push(c2h_push), .out_byte(c2h_in), .in_pop(h2c_pop));

    // R4: a host push into an empty queue raises status bit 1 at the next edge
    a_r4_status_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (h2c_push && h2c_level == '0) |=> status[1]);
    // R7: status bit 0 stays set while the CPU pushes and the host does not pop
    a_r7_full_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !c2h_pop) |=> status[0]);
endmodule

// File: tb/vuart_bridge_tb.sv
`timescale 1ns/1ps
module vuart_bridge_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_re, host_we, cpu_re, cpu_we;
    logic [4:0]  host_addr, cpu_addr;
    logic [31:0] host_wdata, cpu_wdata, host_rdata, cpu_rdata;

    int compared = 0;
    int mismatched = 0;
    string phase = "";
    logic [7:0] q_h2c[$];
    logic [7:0] q_c2h[$];

    always #2 clk = ~clk;

    vuart_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_re(host_re), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cpu_re(cpu_re), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata));

    function automatic logic [31:0] status_word();
        return {30'd0, q_h2c.size() != 0, q_c2h.size() == DEPTH};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then update the model
    task automatic cyc(input logic hre, input logic hwe, input logic [4:0] ha,
                       input logic [7:0] hd, input logic cre, input logic cwe,
                       input logic [4:0] ca, input logic [7:0] cd);
        logic [31:0] eh, ec;
        string th, tc;
        bit h2c_pop, c2h_pop, h2c_push, c2h_push;
        @(negedge clk);
        host_re = hre; host_we = hwe; host_addr = ha;
        host_wdata = {24'hA5A5A5, hd};
        cpu_re = cre; cpu_we = cwe; cpu_addr = ca;
        cpu_wdata = {24'h5A5A5A, cd};
        #1;
        eh = '0; th = "R10";
        if (hre) begin
            case (ha)
                5'h00: begin eh = status_word(); th = "R4"; end
                5'h10: begin eh[8] = q_h2c.size() < DEPTH; th = "R8"; end
                5'h14: if (q_c2h.size() != 0) begin
                           eh = {7'd0, 16'(q_c2h.size()), 1'b1, q_c2h[0]}; th = "R5";
                       end else th = "R6";
                default: th = "R10";
            endcase
        end
        ec = '0; tc = "R10";
        if (cre) begin
            case (ca)
                5'h00: begin ec = status_word(); tc = "R7"; end
                5'h04: begin ec[8] = q_c2h.size() < DEPTH; tc = "R8"; end
                5'h08: begin
                    if (q_h2c.size() != 0) ec = {23'd0, 1'b1, q_h2c[0]};
                    tc = "R2";
                end
                default: tc = "R10";
            endcase
        end
        if (phase == "R1") begin th = "R1"; tc = "R1"; end
        check(th, host_rdata, eh);
        check(tc, cpu_rdata, ec);
        h2c_pop  = cre && ca == 5'h08 && q_h2c.size() != 0;
        c2h_pop  = hre && ha == 5'h14 && q_c2h.size() != 0;
        h2c_push = hwe && ha == 5'h10 && q_h2c.size() < DEPTH;
        c2h_push = cwe && ca == 5'h04 && q_c2h.size() < DEPTH;
        @(posedge clk);
        if (h2c_pop)  void'(q_h2c.pop_front());
        if (c2h_pop)  void'(q_c2h.pop_front());
        if (h2c_push) q_h2c.push_back(hd);
        if (c2h_push) q_c2h.push_back(cd);
    endtask

    function automatic logic [4:0] pick_addr();
        case ($urandom_range(0, 5))
            0: return 5'h00;
            1: return 5'h04;
            2: return 5'h08;
            3: return 5'h10;
            4: return 5'h14;
            default: return 5'h0C;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #400000;
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        host_re = 0; host_we = 0; cpu_re = 0; cpu_we = 0;
        host_addr = '0; cpu_addr = '0; host_wdata = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state seen through status and both receive words
        phase = "R1";
        cyc(1, 0, 5'h00, 0, 1, 0, 5'h00, 0);
        cyc(1, 0, 5'h14, 0, 1, 0, 5'h08, 0);

        // R3 / R4 / R8: fill host-to-CPU past full, polling as we go
        phase = "R3 overflow";
        for (int i = 0; i < 20; i++) cyc(1, 1, 5'h10, 8'(8'h30 + i), 1, 0, 5'h00, 0);
        cyc(1, 0, 5'h10, 0, 1, 0, 5'h00, 0);
        // R2 / R9: CPU drains in order, with extra reads on empty
        phase = "R9 cpu drain";
        for (int i = 0; i < 18; i++) cyc(1, 0, 5'h00, 0, 1, 0, 5'h08, 0);

        // R7: fill CPU-to-host past full
        phase = "R7 overflow";
        for (int i = 0; i < 19; i++) cyc(0, 0, 5'h00, 0, 1, 1, 5'h04, 8'(8'hC0 + i));
        cyc(1, 0, 5'h00, 0, 1, 0, 5'h04, 0);
        // R5 / R6: host drains until the valid flag clears
        phase = "R5 host drain";
        for (int i = 0; i < 18; i++) cyc(1, 0, 5'h14, 0, 1, 0, 5'h00, 0);

        // R9: simultaneous push and pop on an empty and a loaded queue
        phase = "R9 same cycle";
        cyc(0, 1, 5'h10, 8'h77, 1, 0, 5'h08, 0);
        cyc(0, 1, 5'h10, 8'h78, 1, 0, 5'h08, 0);
        cyc(0, 0, 5'h00, 0, 1, 0, 5'h08, 0);

        // R10: strobes at unmapped offsets and with read low
        phase = "R10 decode";
        cyc(0, 0, 5'h14, 0, 0, 1, 5'h04, 8'h11);
        cyc(1, 0, 5'h0C, 0, 1, 0, 5'h1C, 0);
        cyc(1, 0, 5'h14, 0, 1, 0, 5'h00, 0);

        // Mixed traffic across all requirements
        phase = "R9 mixed";
        for (int i = 0; i < 3000; i++)
            cyc($urandom_range(0, 1), $urandom_range(0, 1), pick_addr(), 8'($urandom),
                $urandom_range(0, 1), $urandom_range(0, 1), pick_addr(), 8'($urandom));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule